// File: doc/BRIEF.md
# Four-channel programmable down-counter timer

This block is a memory-mapped timer unit with four independent down-counters and one shared interrupt line. Software programs each channel through a small register bus with address, write data, a write strobe and combinational read data. Each channel holds a start value, a reload value that is used only when the count next runs out, a control byte, and a readable live count. Because the counters run downward, software that needs elapsed time reads the inverted or negated live count.

A channel's control byte selects the counting width (the full counter width or the low 16 bits), a tick divider of 1, 16 or 256, and one of three behaviours when the count reaches zero. It can park at zero (single-shot), reload from the channel's reload register (repeating), or wrap to the all-ones value of the selected width (free-running). A shared interrupt section records a sticky flag for each channel when its count steps from one to zero. It gates the flags with an enable mask and ORs the result onto one interrupt output. Software clears the flags by writing ones.

Top module: `tick_timer_quad`

## Requirements
- R1: After reset the interrupt output is low, the mask, raw-status and control registers read 0, every start-value register reads 0xFFFFFFFF and every live count reads 0x0000FFFF, because a zero control byte selects 16-bit counting.
- R2: Shared registers sit at byte address 0x00 (mask), 0x04 (raw flags), 0x08 (masked flags) and 0x0C (clear). Channel n (0 to 3) has a block at 0x10 + 0x10·n with the start value at +0x0, the live count at +0x4, the control byte at +0x8 and the reload value at +0xC. The control byte and the reload value read back as written. Writes to the raw-flag address have no effect.
- R3: A write to the start-value register loads the live count on the same clock edge. While control bit 7 is set and the divider is 1, the count drops by one on every clock. While bit 7 is clear, the count holds.
- R4: With control bit 0 set (single-shot), a count that has reached zero stays at zero while the channel remains enabled.
- R5: With bit 0 clear and bit 6 set (repeating), the tick after the count reaches zero loads the current reload value. A reload-value write made before that tick does not change the count in progress.
- R6: With bits 0 and 6 clear (free-running), the tick after zero loads the all-ones value of the selected width.
- R7: Raw flag bit n is set on the edge where channel n's enabled count steps from 1 to 0. It stays set until a write of 1 to bit n of the clear register. If a set and a clear fall on the same edge, the flag stays set.
- R8: The masked-flag register equals the raw flags ANDed with the mask (1 = enabled). The interrupt output is high exactly when any masked bit is set.
- R9: Control bits 3:2 pick the divider: 00 gives 1, 01 gives 16, and 10 or 11 gives 256. A write to the control register restarts the divider phase, so the first decrement comes exactly one divider period after that write.
- R10: With control bit 1 clear, only the low 16 bits count. The live count reads zero-extended, and free-running wrap gives 0xFFFF. With bit 1 set, all 32 bits count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle in which it is high |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Combined interrupt, OR of the masked flags |

## Verification
A wrong divider phase or count value shows at the live-count address within one divider period. The bench reads the count one cycle before and one cycle after each expected decrement, so an off-by-one in either direction is caught on that cycle. A wrong reload source or wrap value becomes visible on the tick after zero. Raw-flag mistakes appear on the interrupt pin and the flag registers on the edge that should set or clear them. The bench lines its stimulus up so that a flag set and a clear write fall on the same edge.

// File: rtl/ttq_pkg.sv
package ttq_pkg;
   localparam int CTL_W    = 8;
   localparam int CTL_EN   = 7;
   localparam int CTL_PER  = 6;
   localparam int CTL_PSHI = 3;
   localparam int CTL_PSLO = 2;
   localparam int CTL_WIDE = 1;
   localparam int CTL_ONCE = 0;

   typedef enum logic [1:0] {
      PSC_DIV1   = 2'b00,
      PSC_DIV16  = 2'b01,
      PSC_DIV256 = 2'b10,
      PSC_ALT256 = 2'b11
   } psc_sel_e;

   // register offsets inside a 16-byte block
   localparam logic [3:0] OFS_MASK  = 4'h0;
   localparam logic [3:0] OFS_RAW   = 4'h4;
   localparam logic [3:0] OFS_MSKD  = 4'h8;
   localparam logic [3:0] OFS_CLR   = 4'hC;
   localparam logic [3:0] OFS_START = 4'h0;
   localparam logic [3:0] OFS_LIVE  = 4'h4;
   localparam logic [3:0] OFS_CTRL  = 4'h8;
   localparam logic [3:0] OFS_RELD  = 4'hC;
endpackage

// File: rtl/ttq_prescaler.sv
module ttq_prescaler
   import ttq_pkg::*;
#(
   parameter int MID_LOG2 = 4,
   parameter int HI_LOG2  = 8
)(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     run,
   input  logic     restart,
   input  psc_sel_e sel,
   output logic     tick
);
   if (MID_LOG2 < 1 || HI_LOG2 <= MID_LOG2) begin : g_bad_div
      $error("ttq_prescaler: need 1 <= MID_LOG2 < HI_LOG2");
   end

   logic [HI_LOG2-1:0] phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       phase_q <= '0;
      else if (restart) phase_q <= '0;
      else if (run)     phase_q <= phase_q + 1'b1;
   end

   always_comb begin
      unique case (sel)
         PSC_DIV1:  tick = run;
         PSC_DIV16: tick = run && (&phase_q[MID_LOG2-1:0]);
         default:   tick = run && (&phase_q);
      endcase
   end
endmodule

// File: rtl/ttq_channel.sv
module ttq_channel
   import ttq_pkg::*;
#(
   parameter int CNT_W        = 32,
   parameter int NARROW_W     = 16,
   parameter int PSC_MID_LOG2 = 4,
   parameter int PSC_HI_LOG2  = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] wdata,
   input  logic             we_start,
   input  logic             we_ctrl,
   input  logic             we_reld,
   output logic [CTL_W-1:0] ctrl_o,
   output logic [CNT_W-1:0] start_o,
   output logic [CNT_W-1:0] reld_o,
   output logic [CNT_W-1:0] live_o,
   output logic             event_o
);
   if (NARROW_W < 1 || NARROW_W >= CNT_W) begin : g_bad_w
      $error("ttq_channel: need 1 <= NARROW_W < CNT_W");
   end

   localparam logic [CNT_W-1:0] ALL_ONES    = '1;
   localparam logic [CNT_W-1:0] NARROW_MASK = {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
   localparam logic [CNT_W-1:0] ONE         = CNT_W'(1);

   logic [CTL_W-1:0] ctl_q;
   logic [CNT_W-1:0] start_q, reld_q, cnt_q, cnt_d;
   logic [CNT_W-1:0] wmask, cnt_eff, reld_eff;
   logic             tick, at_zero, at_one;

   assign wmask    = ctl_q[CTL_WIDE] ? ALL_ONES : NARROW_MASK;
   assign cnt_eff  = cnt_q & wmask;
   assign reld_eff = reld_q & wmask;
   assign at_zero  = (cnt_eff == '0);
   assign at_one   = (cnt_eff == ONE);

   ttq_prescaler #(.MID_LOG2(PSC_MID_LOG2), .HI_LOG2(PSC_HI_LOG2)) u_psc (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (ctl_q[CTL_EN]),
      .restart (we_ctrl),
      .sel     (psc_sel_e'(ctl_q[CTL_PSHI:CTL_PSLO])),
      .tick    (tick)
   );

   always_comb begin
      cnt_d = cnt_q;
      if (we_start) begin
         cnt_d = wdata;
      end else if (tick) begin
         if (!at_zero)                cnt_d = cnt_eff - ONE;
         else if (ctl_q[CTL_ONCE])    cnt_d = cnt_eff;
         else if (ctl_q[CTL_PER])     cnt_d = reld_eff;
         else                         cnt_d = wmask;
      end
   end

   assign event_o = tick && at_one && !we_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q   <= '0;
         start_q <= ALL_ONES;
         reld_q  <= ALL_ONES;
         cnt_q   <= ALL_ONES;
      end else begin
         if (we_ctrl)  ctl_q   <= wdata[CTL_W-1:0];
         if (we_start) start_q <= wdata;
         if (we_reld)  reld_q  <= wdata;
         cnt_q <= cnt_d;
      end
   end

   assign ctrl_o  = ctl_q;
   assign start_o = start_q;
   assign reld_o  = reld_q;
   assign live_o  = cnt_eff;
endmodule

// File: rtl/ttq_irq.sv
module ttq_irq #(
   parameter int NUM_CH = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] ev,
   input  logic              we_mask,
   input  logic              we_clr,
   input  logic [NUM_CH-1:0] wbits,
   output logic [NUM_CH-1:0] mask_o,
   output logic [NUM_CH-1:0] raw_o,
   output logic [NUM_CH-1:0] masked_o,
   output logic              irq_o
);
   logic [NUM_CH-1:0] mask_q, raw_q, clr_bits;

   assign clr_bits = we_clr ? wbits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         raw_q  <= '0;
      end else begin
         if (we_mask) mask_q <= wbits;
         raw_q <= ev | (raw_q & ~clr_bits);
      end
   end

   assign mask_o   = mask_q;
   assign raw_o    = raw_q;
   assign masked_o = raw_q & mask_q;
   assign irq_o    = |masked_o;
endmodule

// File: rtl/tick_timer_quad.sv
module tick_timer_quad
   import ttq_pkg::*;
#(
   parameter int NUM_CH       = 4,
   parameter int DATA_W       = 32,
   parameter int CNT_W        = 32,
   parameter int NARROW_W     = 16,
   parameter int ADDR_W       = 8,
   parameter int PSC_MID_LOG2 = 4,
   parameter int PSC_HI_LOG2  = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o
);
   localparam int BLK_W = ADDR_W - 4;

   if (BLK_W < $clog2(NUM_CH + 1)) begin : g_bad_addr
      $error("tick_timer_quad: ADDR_W too small for NUM_CH");
   end
   if (CNT_W > DATA_W || NUM_CH > DATA_W || DATA_W < CTL_W) begin : g_bad_data
      $error("tick_timer_quad: DATA_W too small");
   end

   logic [BLK_W-1:0]  blk;
   logic [3:0]        ofs;
   logic              we_mask, we_clr;
   logic [NUM_CH-1:0] start_we, ctrl_we, reld_we, ev, clr_v;
   logic [NUM_CH-1:0] mask_r, raw_st, masked;
   logic [CNT_W-1:0]  start_v [NUM_CH];
   logic [CNT_W-1:0]  reld_v  [NUM_CH];
   logic [CNT_W-1:0]  live_v  [NUM_CH];
   logic [CTL_W-1:0]  ctrl_v  [NUM_CH];
   logic [NUM_CH*CNT_W-1:0] live_flat;
   logic [NUM_CH*CTL_W-1:0] ctrl_flat;

   assign blk     = bus_addr[ADDR_W-1:4];
   assign ofs     = bus_addr[3:0];
   assign we_mask = bus_we && (blk == '0) && (ofs == OFS_MASK);
   assign we_clr  = bus_we && (blk == '0) && (ofs == OFS_CLR);
   assign clr_v   = we_clr ? bus_wdata[NUM_CH-1:0] : '0;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic hit;
      assign hit         = bus_we && (blk == BLK_W'(g + 1));
      assign start_we[g] = hit && (ofs == OFS_START);
      assign ctrl_we[g]  = hit && (ofs == OFS_CTRL);
      assign reld_we[g]  = hit && (ofs == OFS_RELD);

      ttq_channel #(
         .CNT_W(CNT_W), .NARROW_W(NARROW_W),
         .PSC_MID_LOG2(PSC_MID_LOG2), .PSC_HI_LOG2(PSC_HI_LOG2)
      ) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .wdata    (bus_wdata[CNT_W-1:0]),
         .we_start (start_we[g]),
         .we_ctrl  (ctrl_we[g]),
         .we_reld  (reld_we[g]),
         .ctrl_o   (ctrl_v[g]),
         .start_o  (start_v[g]),
         .reld_o   (reld_v[g]),
         .live_o   (live_v[g]),
         .event_o  (ev[g])
      );

      assign live_flat[g*CNT_W +: CNT_W] = live_v[g];
      assign ctrl_flat[g*CTL_W +: CTL_W] = ctrl_v[g];
   end

   ttq_irq #(.NUM_CH(NUM_CH)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev       (ev),
      .we_mask  (we_mask),
      .we_clr   (we_clr),
      .wbits    (bus_wdata[NUM_CH-1:0]),
      .mask_o   (mask_r),
      .raw_o    (raw_st),
      .masked_o (masked),
      .irq_o    (irq_o)
   );

   always_comb begin
      bus_rdata = '0;
      if (blk == '0) begin
         case (ofs)
            OFS_MASK: bus_rdata[NUM_CH-1:0] = mask_r;
            OFS_RAW:  bus_rdata[NUM_CH-1:0] = raw_st;
            OFS_MSKD: bus_rdata[NUM_CH-1:0] = masked;
            default:  bus_rdata = '0;
         endcase
      end else begin
         for (int i = 0; i < NUM_CH; i++) begin
            if (blk == BLK_W'(i + 1)) begin
               case (ofs)
                  OFS_START: bus_rdata[CNT_W-1:0] = start_v[i];
                  OFS_LIVE:  bus_rdata[CNT_W-1:0] = live_v[i];
                  OFS_CTRL:  bus_rdata[CTL_W-1:0] = ctrl_v[i];
                  OFS_RELD:  bus_rdata[CNT_W-1:0] = reld_v[i];
                  default:   bus_rdata = '0;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/ttq_checker.sv
module ttq_checker
   import ttq_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int CNT_W  = 32
)(
   input logic                    clk,
   input logic                    rst_n,
   input logic                    irq_o,
   input logic [NUM_CH-1:0]       raw_st,
   input logic [NUM_CH-1:0]       mask_r,
   input logic [NUM_CH-1:0]       ev,
   input logic [NUM_CH-1:0]       clr_v,
   input logic [NUM_CH-1:0]       start_we,
   input logic [NUM_CH*CNT_W-1:0] live_flat,
   input logic [NUM_CH*CTL_W-1:0] ctrl_flat
);
   AST_MASK_GATES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_r == '0) |-> !irq_o); // R8
   AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (raw_st != '0)); // R8

   for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
      logic             en, once;
      logic [CNT_W-1:0] live;
      assign en   = ctrl_flat[g*CTL_W + CTL_EN];
      assign once = ctrl_flat[g*CTL_W + CTL_ONCE];
      assign live = live_flat[g*CNT_W +: CNT_W];

      AST_ONESHOT_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
         (en && once && live == '0 && !start_we[g]) |=> (live == '0)); // R4
      AST_EVENT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
         ev[g] |-> en); // R7
      AST_EVENT_HITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         ev[g] |=> (live == '0)); // R7
      AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
         ev[g] |=> raw_st[g]); // R7
      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (raw_st[g] && !clr_v[g]) |=> raw_st[g]); // R7
      AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_v[g] && !ev[g]) |=> !raw_st[g]); // R7
   end
endmodule

bind tick_timer_quad ttq_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_ttq_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq_o     (irq_o),
   .raw_st    (raw_st),
   .mask_r    (mask_r),
   .ev        (ev),
   .clr_v     (clr_v),
   .start_we  (start_we),
   .live_flat (live_flat),
   .ctrl_flat (ctrl_flat)
);

// File: tb/tb_tick_timer_quad.sv
`timescale 1ns/1ps
module tb_tick_timer_quad;
   localparam logic [7:0] EN = 8'h80, PER = 8'h40, WIDE = 8'h02, ONCE = 8'h01;
   localparam logic [7:0] A_MASK = 8'h00, A_RAW = 8'h04, A_MSKD = 8'h08, A_CLR = 8'h0C;
   localparam int O_START = 0, O_LIVE = 4, O_CTRL = 8, O_RELD = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_rdata;
   logic        irq_o;
   int vectors = 0;
   int miscompares = 0;

   always #10 clk = ~clk;

   tick_timer_quad dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   function automatic logic [7:0] ca(input int n, input int o);
      return 8'(8'h10 + n * 16 + o);
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      vectors++;
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
      bus_we   = 1'b0;
      bus_addr = a;
      #2;
      chk(req, bus_rdata, exp);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
   endtask

   initial begin
      #(200000 * 20);
      miscompares++;
      $display("FAIL watchdog R3 run did not finish");
      summary();
      $finish;
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);

      // R1 reset state
      chk("R1 irq", {31'b0, irq_o}, 32'h0);
      rd("R1 mask", A_MASK, 32'h0);
      rd("R1 raw", A_RAW, 32'h0);
      for (int n = 0; n < 4; n++) begin
         rd("R1 ctrl", ca(n, O_CTRL), 32'h0);
         rd("R1 start", ca(n, O_START), 32'hFFFF_FFFF);
         rd("R1 live", ca(n, O_LIVE), 32'h0000_FFFF);
      end

      // R2 map and readback; raw flags are read-only
      wr(ca(2, O_RELD), 32'h1234_5678);
      rd("R2 reload readback", ca(2, O_RELD), 32'h1234_5678);
      wr(ca(3, O_CTRL), 32'h0000_002E);
      rd("R2 ctrl readback", ca(3, O_CTRL), 32'h0000_002E);
      wr(A_RAW, 32'hF);
      rd("R2 raw write ignored", A_RAW, 32'h0);
      wr(ca(3, O_CTRL), 32'h0);
      wr(A_MASK, 32'hF);
      rd("R2 mask readback", A_MASK, 32'hF);

      // R3 R4 R7 R8 single-shot sweep over every channel
      for (int n = 0; n < 4; n++) begin
         int len;
         len = 3 + n;
         wr(ca(n, O_START), 32'(len));
         wr(ca(n, O_CTRL), 32'(EN | WIDE | ONCE));
         rd("R3 start loads count", ca(n, O_LIVE), 32'(len));
         step(len - 1);
         rd("R3 count by one", ca(n, O_LIVE), 32'h1);
         rd("R7 no flag before zero", A_RAW, 32'h0);
         step(1);
         rd("R3 reached zero", ca(n, O_LIVE), 32'h0);
         rd("R7 flag set", A_RAW, 32'(1 << n));
         rd("R8 masked flags", A_MSKD, 32'(1 << n));
         chk("R8 irq high", {31'b0, irq_o}, 32'h1);
         step(5);
         rd("R4 parked at zero", ca(n, O_LIVE), 32'h0);
         wr(A_CLR, 32'(1 << n));
         rd("R7 cleared", A_RAW, 32'h0);
         chk("R8 irq low", {31'b0, irq_o}, 32'h0);
         wr(ca(n, O_CTRL), 32'h0);
         wr(ca(n, O_START), 32'd9);
         step(4);
         rd("R3 disabled holds", ca(n, O_LIVE), 32'd9);
      end

      // R7 set wins over a clear on the same edge
      wr(ca(1, O_START), 32'd2);
      wr(ca(1, O_CTRL), 32'(EN | WIDE | ONCE));
      step(1);
      wr(A_CLR, 32'h2);
      rd("R7 set beats clear", A_RAW, 32'h2);
      wr(A_CLR, 32'h2);
      rd("R7 later clear", A_RAW, 32'h0);
      wr(ca(1, O_CTRL), 32'h0);

      // R8 mask gating
      wr(A_MASK, 32'h0);
      wr(ca(0, O_START), 32'd1);
      wr(ca(0, O_CTRL), 32'(EN | WIDE | ONCE));
      step(1);
      rd("R8 raw while masked", A_RAW, 32'h1);
      rd("R8 masked zero", A_MSKD, 32'h0);
      chk("R8 irq masked off", {31'b0, irq_o}, 32'h0);
      wr(A_MASK, 32'h1);
      rd("R8 masked on", A_MSKD, 32'h1);
      chk("R8 irq on", {31'b0, irq_o}, 32'h1);
      wr(ca(0, O_CTRL), 32'h0);
      wr(A_CLR, 32'hF);

      // R5 repeating mode with a reload write mid-count
      wr(ca(2, O_START), 32'd3);
      wr(ca(2, O_RELD), 32'd5);
      wr(ca(2, O_CTRL), 32'(EN | PER | WIDE));
      step(2);
      rd("R5 counting", ca(2, O_LIVE), 32'd1);
      wr(ca(2, O_RELD), 32'd9);
      rd("R5 reload write leaves count", ca(2, O_LIVE), 32'd0);
      step(1);
      rd("R5 reloaded new value", ca(2, O_LIVE), 32'd9);
      step(9);
      rd("R5 zero again", ca(2, O_LIVE), 32'd0);
      step(1);
      rd("R5 reload repeats", ca(2, O_LIVE), 32'd9);
      rd("R7 repeating flag", A_RAW, 32'h4);
      wr(ca(2, O_CTRL), 32'h0);
      wr(A_CLR, 32'hF);

      // R6 free-running wrap, full width
      wr(ca(3, O_START), 32'd1);
      wr(ca(3, O_CTRL), 32'(EN | WIDE));
      step(1);
      rd("R6 at zero", ca(3, O_LIVE), 32'h0);
      step(1);
      rd("R6 wrap 32", ca(3, O_LIVE), 32'hFFFF_FFFF);
      step(1);
      rd("R6 after wrap", ca(3, O_LIVE), 32'hFFFF_FFFE);

      // R10 narrow counting
      wr(ca(3, O_CTRL), 32'(EN));
      wr(ca(3, O_START), 32'h0001_0002);
      rd("R10 zero-extended", ca(3, O_LIVE), 32'h0000_0002);
      rd("R10 start keeps all bits", ca(3, O_START), 32'h0001_0002);
      step(2);
      rd("R10 narrow zero", ca(3, O_LIVE), 32'h0);
      step(1);
      rd("R10 narrow wrap", ca(3, O_LIVE), 32'h0000_FFFF);
      step(1);
      rd("R10 narrow after wrap", ca(3, O_LIVE), 32'h0000_FFFE);
      wr(ca(3, O_CTRL), 32'h0);
      rd("R10 stop", ca(3, O_LIVE), 32'h0000_FFFD);
      rd("R7 narrow flag", A_RAW, 32'h8);
      wr(A_CLR, 32'hF);

      // R9 divider sweep and phase restart
      for (int ps = 1; ps <= 3; ps++) begin
         int d;
         d = (ps == 1) ? 16 : 256;
         wr(ca(0, O_START), 32'd10);
         wr(ca(0, O_CTRL), 32'(EN | WIDE | 8'(ps << 2)));
         step(d - 1);
         rd("R9 before first tick", ca(0, O_LIVE), 32'd10);
         step(1);
         rd("R9 first tick", ca(0, O_LIVE), 32'd9);
         step(d);
         rd("R9 second tick", ca(0, O_LIVE), 32'd8);
         step(d / 2);
         wr(ca(0, O_CTRL), 32'(EN | WIDE | 8'(ps << 2)));
         step(d - 1);
         rd("R9 restart delays tick", ca(0, O_LIVE), 32'd8);
         step(1);
         rd("R9 tick after restart", ca(0, O_LIVE), 32'd7);
         wr(ca(0, O_CTRL), 32'h0);
      end

      summary();
      $finish;
   end
endmodule